// File: doc/BRIEF.md
# Bounded SPI Slave Frame Receiver

This block receives bytes as an SPI slave over a single data line, with no transmit path. A capacity in bytes is loaded while the block is idle. The block then waits for the active-low chip select to fall. It samples MOSI on each rising edge of SCK, assembling bits most-significant first. Each time eight bits are complete, it presents the byte with a one-cycle valid strobe. The capacity is held internally as a bit budget. Once the budget is used up, any further bit moves the receiver into a frozen overrun state. In that state it stores and emits nothing until chip select is released.

SCK, MOSI and chip select are sampled in the system clock domain. Each passes through a synchronizer chain, and edges are found on the synchronized copies. When chip select rises after an armed capture, the block raises a one-cycle done pulse. It also updates the count of whole bytes received and an overflow flag. Both values hold until the next done pulse. A trailing partial byte is dropped.

Top module: `spi_frame_rx`

## Requirements
- R1: While reset is asserted and on the first cycles after it, byte_vld_o, done_o, overflow_o and rx_count_o are all 0.
- R2: After a capacity load, no bit is taken until chip select (csn_i, active low) is seen low. SCK rising edges while chip select is still high produce no byte and consume no budget.
- R3: Bits are taken on SCK rising edges and shifted in MSB first: the first bit of a byte lands in byte_o[7]. After each eighth bit, byte_vld_o is high for exactly one clock with the completed byte on byte_o.
- R4: The budget starts at capacity×8 bits. It is tested for zero before being decremented on each bit. A bit arriving at zero budget freezes the receiver, and from then on no further byte is emitted. At frame end overflow_o is 1 and rx_count_o equals the capacity. A capacity of 0 overruns on the first bit.
- R5: A rising edge of chip select after an armed capture gives done_o high for exactly one clock. In that same cycle rx_count_o shows the number of whole bytes received, and overflow_o is 0 when no overrun occurred.
- R6: A partial byte of fewer than 8 bits pending at chip-select rise is neither emitted nor counted.
- R7: A chip-select rise when no capacity was loaded produces no done pulse and no byte.
- R8: A capacity load is accepted only while idle; a load during a frame has no effect on that frame. After done, the receiver is idle and accepts a new load.
- R9: rx_count_o and overflow_o keep their values from one done pulse until the next, including across a new capacity load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI clock from the master, asynchronous |
| mosi_i | input | 1 | SPI data from the master, asynchronous |
| csn_i | input | 1 | Active-low chip select, asynchronous |
| cap_load_i | input | 1 | Load strobe for the byte capacity (taken when idle) |
| cap_bytes_i | input | CAP_W | Byte capacity for the next frame |
| byte_o | output | 8 | Last completed byte |
| byte_vld_o | output | 1 | One-cycle strobe marking a new byte on byte_o |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rx_count_o | output | CAP_W | Whole bytes received in the last frame |
| overflow_o | output | 1 | The last frame overran its capacity |

## Verification
A budget counter that is off by one shows up as a missing or extra byte strobe. It also gives a wrong rx_count_o at the next done pulse, so it surfaces by the end of the frame at the latest. A state machine stuck outside idle refuses the next capacity load. That is seen as an absent done pulse one frame later. Errors in bit order or bit count corrupt byte_o at the very first strobe. A frozen state that still stores data shows up as strobes beyond the capacity within eight SCK periods.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  // log2 of bits per byte; byte size derived from it
  localparam int BYTE_LG = 3;
  localparam int BYTE_W  = 1 << BYTE_LG;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_ARMED  = 2'd1,
    RX_TAKE   = 2'd2,
    RX_FROZEN = 2'd3
  } rx_state_e;
endpackage

// File: rtl/spi_rx_sync.sv
// Multi-bit synchronizer chain, one independent chain per bit.
module spi_rx_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= raw_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_edge.sv
// Rising-edge detector on already synchronized lines.
module spi_rx_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/spi_rx_shift.sv
// MSB-first bit assembler; strobes a byte after every BYTE_W bits.
module spi_rx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_next;
  logic [CNT_W-1:0]  cnt_q;

  assign sh_next = {sh_q[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      byte_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (take_i) begin
        sh_q <= sh_next;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          byte_o <= sh_next;
          vld_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_rx_pkg::*;
#(
  parameter int CAP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  input  logic              cap_load_i,
  input  logic [CAP_W-1:0]  cap_bytes_i,
  output logic [7:0]        byte_o,
  output logic              byte_vld_o,
  output logic              done_o,
  output logic [CAP_W-1:0]  rx_count_o,
  output logic              overflow_o
);
  localparam int BUD_W = CAP_W + BYTE_LG;

  // ---------------- arithmetic ----------------
  function automatic logic [BUD_W-1:0] cap_to_bits(input logic [CAP_W-1:0] c);
    return {c, {BYTE_LG{1'b0}}};
  endfunction

  // bytes still open, rounding a partly filled byte up so it is not counted
  function automatic logic [CAP_W-1:0] bytes_open(input logic [BUD_W-1:0] b);
    logic [BUD_W:0] r;
    r = {1'b0, b} + (BUD_W+1)'(BYTE_W - 1);
    return CAP_W'(r >> BYTE_LG);
  endfunction

  function automatic logic [CAP_W-1:0] bytes_got(input logic [CAP_W-1:0] c,
                                                 input logic [BUD_W-1:0] b,
                                                 input logic             ovf);
    return ovf ? c : c - bytes_open(b);
  endfunction

  // ---------------- input conditioning ----------------
  // line order: [2] chip select, [1] SCK, [0] MOSI
  logic [2:0] lines_s;
  logic [1:0] rise;

  spi_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({csn_i, sck_i, mosi_i}),
    .sync_o (lines_s)
  );

  spi_rx_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lines_s[2:1]),
    .rise_o (rise)
  );

  // ---------------- named events ----------------
  rx_state_e        st;
  logic [BUD_W-1:0] budget_q;
  logic [CAP_W-1:0] cap_q;

  logic sck_rise, cs_rise, cs_low, mosi_s;
  logic load_ok, bit_take, overrun_hit, frame_end;

  assign mosi_s      = lines_s[0];
  assign cs_low      = ~lines_s[2];
  assign sck_rise    = rise[0];
  assign cs_rise     = rise[1];
  assign load_ok     = (st == RX_IDLE) && cap_load_i;
  assign frame_end   = ((st == RX_TAKE) || (st == RX_FROZEN)) && cs_rise;
  assign bit_take    = (st == RX_TAKE) && !cs_rise && sck_rise && (budget_q != '0);
  assign overrun_hit = (st == RX_TAKE) && !cs_rise && sck_rise && (budget_q == '0);

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      budget_q   <= '0;
      cap_q      <= '0;
      done_o     <= 1'b0;
      rx_count_o <= '0;
      overflow_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        RX_IDLE: if (load_ok) begin
          cap_q    <= cap_bytes_i;
          budget_q <= cap_to_bits(cap_bytes_i);
          st       <= RX_ARMED;
        end
        RX_ARMED: if (cs_low) st <= RX_TAKE;
        RX_TAKE: begin
          if (frame_end) begin
            st         <= RX_IDLE;
            done_o     <= 1'b1;
            rx_count_o <= bytes_got(cap_q, budget_q, 1'b0);
            overflow_o <= 1'b0;
          end else if (overrun_hit) begin
            st <= RX_FROZEN;
          end else if (bit_take) begin
            budget_q <= budget_q - 1'b1;
          end
        end
        RX_FROZEN: if (frame_end) begin
          st         <= RX_IDLE;
          done_o     <= 1'b1;
          rx_count_o <= bytes_got(cap_q, budget_q, 1'b1);
          overflow_o <= 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // ---------------- datapath ----------------
  spi_rx_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (load_ok),
    .take_i (bit_take),
    .bit_i  (mosi_s),
    .byte_o (byte_o),
    .vld_o  (byte_vld_o)
  );
endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk
  import spi_rx_pkg::*;
#(
  parameter int CAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input rx_state_e        st,
  input logic [CAP_W-1:0] cap_q,
  input logic             byte_vld_o,
  input logic             done_o,
  input logic [CAP_W-1:0] rx_count_o,
  input logic             overflow_o
);
  // R2: a byte can only appear after the receiver was taking bits
  assert_vld_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> $past(st == RX_TAKE));

  // R3: byte strobe lasts a single cycle
  assert_vld_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  // R4: frozen receiver stores nothing
  assert_frozen_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_FROZEN) |-> !byte_vld_o);

  // R4: count never exceeds capacity, equals it on overflow
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rx_count_o <= cap_q));
  assert_ovf_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overflow_o) |-> (rx_count_o == cap_q));

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done only follows an armed capture
  assert_done_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past((st == RX_TAKE) || (st == RX_FROZEN)));

  // R9: results hold between done pulses
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(rx_count_o) && $stable(overflow_o)));
endmodule

bind spi_frame_rx spi_frame_rx_chk #(.CAP_W(CAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st),
  .cap_q      (cap_q),
  .byte_vld_o (byte_vld_o),
  .done_o     (done_o),
  .rx_count_o (rx_count_o),
  .overflow_o (overflow_o)
);

// File: tb/tb_spi_frame_rx.sv
`timescale 1ns/100ps
module tb_spi_frame_rx;
  localparam int CAP_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             sck = 1'b0, mosi = 1'b0, csn = 1'b1, cap_load = 1'b0;
  logic [CAP_W-1:0] cap_bytes = '0;
  logic [7:0]       byte_o;
  logic             byte_vld_o, done_o, overflow_o;
  logic [CAP_W-1:0] rx_count_o;

  spi_frame_rx #(.CAP_W(CAP_W)) dut (
    .clk (clk), .rst_n (rst_n), .sck_i (sck), .mosi_i (mosi), .csn_i (csn),
    .cap_load_i (cap_load), .cap_bytes_i (cap_bytes),
    .byte_o (byte_o), .byte_vld_o (byte_vld_o), .done_o (done_o),
    .rx_count_o (rx_count_o), .overflow_o (overflow_o)
  );

  int checks = 0, errors = 0;
  int vld_seen = 0, done_seen = 0;
  logic [7:0] got [64];
  logic prev_vld = 1'b0, prev_done = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld_o) begin
        if (vld_seen < 64) got[vld_seen] = byte_o;
        vld_seen++;
        chk("R3", "strobe width", int'(prev_vld), 0);
      end
      if (done_o) begin
        done_seen++;
        chk("R5", "done width", int'(prev_done), 0);
      end
    end
    prev_vld  = byte_vld_o;
    prev_done = done_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] data, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = data[31-i];
      tick(3); sck = 1'b1;
      tick(3); sck = 1'b0;
      tick(3);
    end
  endtask

  task automatic frame(input logic [31:0] data, input int n);
    csn = 1'b0; tick(4);
    send_bits(data, n);
    tick(3); csn = 1'b1; tick(8);
  endtask

  task automatic load(input int c);
    cap_bytes = CAP_W'(c); cap_load = 1'b1; tick(1);
    cap_load = 1'b0; tick(1);
  endtask

  // {capacity, bits sent, data MSB-first, expected count, expected overflow}
  localparam logic [56:0] VEC [8] = '{
    {8'd4, 8'd32, 32'hA53C_0FF0, 8'd4, 1'b0},
    {8'd4, 8'd16, 32'h1234_0000, 8'd2, 1'b0},
    {8'd2, 8'd32, 32'hDEAD_BEEF, 8'd2, 1'b1},
    {8'd3, 8'd20, 32'h8181_F000, 8'd2, 1'b0},
    {8'd0, 8'd8,  32'hFF00_0000, 8'd0, 1'b1},
    {8'd1, 8'd8,  32'h6900_0000, 8'd1, 1'b0},
    {8'd2, 8'd17, 32'hC3E7_8000, 8'd2, 1'b1},
    {8'd5, 8'd0,  32'h0000_0000, 8'd0, 1'b0}
  };

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int d0;
    tick(3);
    // R1: reset state
    chk("R1", "vld in reset", int'(byte_vld_o), 0);
    chk("R1", "done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "count after reset", int'(rx_count_o), 0);
    chk("R1", "overflow after reset", int'(overflow_o), 0);

    // R7: frame without any capacity load
    frame(32'hF0F0_0000, 16);
    chk("R7", "done without arm", done_seen, 0);
    chk("R7", "bytes without arm", vld_seen, 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [7:0]  c, nb, ec;
      logic [31:0] data;
      logic        eo;
      c = VEC[v][56:49]; nb = VEC[v][48:41]; data = VEC[v][40:9];
      ec = VEC[v][8:1];  eo = VEC[v][0];
      vld_seen = 0; d0 = done_seen;
      load(int'(c));
      frame(data, int'(nb));
      chk("R5", "done pulses", done_seen - d0, 1);
      chk("R5", "rx count", int'(rx_count_o), int'(ec));
      chk("R4", "overflow", int'(overflow_o), int'(eo));
      chk("R6", "bytes emitted", vld_seen, int'(ec));
      for (int k = 0; k < int'(ec); k++)
        chk("R3", "byte value", int'(got[k]), int'(data[31-8*k -: 8]));
    end

    // R2: SCK edges while armed but deselected are ignored
    vld_seen = 0;
    load(1);
    send_bits(32'hFFFF_FFFF, 8);
    chk("R2", "bytes before select", vld_seen, 0);
    frame(32'h5A00_0000, 8);
    chk("R2", "count after idle clocks", int'(rx_count_o), 1);
    chk("R2", "no overrun from idle clocks", int'(overflow_o), 0);
    chk("R2", "byte after idle clocks", int'(got[0]), 8'h5A);

    // R8: load during a frame is ignored
    vld_seen = 0;
    load(1);
    csn = 1'b0; tick(4);
    cap_bytes = 8'd9; cap_load = 1'b1; tick(1); cap_load = 1'b0;
    send_bits(32'hAAAA_0000, 16);
    tick(3); csn = 1'b1; tick(8);
    chk("R8", "mid-frame load ignored count", int'(rx_count_o), 1);
    chk("R8", "mid-frame load ignored overflow", int'(overflow_o), 1);

    // R8: idle again, new load accepted
    vld_seen = 0;
    load(2);
    frame(32'h0102_0000, 16);
    chk("R8", "reload count", int'(rx_count_o), 2);
    chk("R8", "reload overflow", int'(overflow_o), 0);

    // R9: results held across idle time and a new load
    tick(20);
    load(3);
    tick(5);
    chk("R9", "count held", int'(rx_count_o), 2);
    chk("R9", "overflow held", int'(overflow_o), 0);
    csn = 1'b0; tick(4);
    send_bits(32'hFFFF_0000, 8);
    chk("R9", "count held mid-frame", int'(rx_count_o), 2);
    csn = 1'b1; tick(8);
    chk("R9", "count updated at done", int'(rx_count_o), 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule